// File: doc/BRIEF.md
# Serial Receive Path with Line Status

This block turns an asynchronous serial input into bytes. It watches the receive line with a sampling strobe running at sixteen times the bit rate. It confirms each start bit at mid-bit and then samples every data, parity and stop position at its centre. Each finished word goes into a small receive queue, together with three error tags: parity, framing and break. A line status byte sums up the state of the receiver for the host.

The host sets the frame format through a line-control byte. The transmitter uses the same byte. The host takes words from the head of the queue with a read strobe. It reads the status byte with a second strobe, and that read clears the sticky error flags. The status byte also carries two transmitter flags. These come from outside the block and pass straight through. When the queue is full, a word that finishes is dropped and the words already queued are kept.

Line-control byte fields used by the receiver:
- bits [1:0]: word length code.
- bit 3: parity enable.
- bit 4: even parity select.
- bit 5: stick parity.

Bits 2, 6 and 7 have no effect on reception. Only the first stop bit is checked.

Top module: `uart_rx_lsr`

## Requirements
- R1: A start bit counts only if the line still reads low 8 strobes after the falling edge is first seen. A low pulse of 3 strobes produces no word, and status bit 0 stays 0.
- R2: Word length code 00, 01, 10 and 11 gives 5, 6, 7 and 8 data bits. Data arrives LSB first. `rd_data` holds the word zero-extended to 8 bits.
- R3: With parity enabled, the expected parity bit depends on the other two fields:
  - bit 5 = 0, bit 4 = 1: the data bits plus the parity bit hold an even number of ones.
  - bit 5 = 0, bit 4 = 0: they hold an odd number of ones.
  - bit 5 = 1: the expected bit is 0 when bit 4 is 1, and 1 when bit 4 is 0.
  
  A mismatch sets status bit 2 and the word's tag `rd_err[0]`.
- R4: A stop bit sampled low sets status bit 3 and the word's tag `rd_err[1]`.
- R5: If the line is low at every data, parity and stop sample, the block queues the word 0x00. It sets status bit 4 and tag `rd_err[2]`, and sets the framing flags as well.
- R6: Status bit 0 is 1 exactly while the queue holds a word. It rises only after the stop position of a word has been sampled.
- R7: A word that finishes while the queue holds `FIFO_DEPTH` (4) words sets status bit 1 and is dropped. The older words come out unchanged and in order.
- R8: Status bits 4 to 1 are sticky. They read 0 from the cycle after an `lsr_rd_stb` pulse, unless a new event sets them in that same cycle.
- R9: Status bit 7 is 1 while any queued word has a nonzero tag. It returns to 0 once all such words have been popped.
- R10: Status bit 6 follows `tx_empty` and status bit 5 follows `tx_hold_empty`.
- R11: `rd_data` and `rd_err` show the head word. A `rd_data_stb` pulse removes the head word.
- R12: After a stop bit sampled low, no new start bit is searched for until the line has returned high. A long break therefore yields only one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_line | input | 1 | Serial receive line; idles high |
| baud_tick | input | 1 | Sampling strobe at 16x the bit rate |
| line_ctrl | input | 8 | Frame format (length, parity fields) |
| rd_data_stb | input | 1 | Pop the head word |
| lsr_rd_stb | input | 1 | Host read of the status byte; clears sticky flags |
| tx_empty | input | 1 | Transmitter fully idle (external) |
| tx_hold_empty | input | 1 | Transmit holding slot free (external) |
| rd_data | output | 8 | Head word data |
| rd_err | output | 3 | Head word tags {break, framing, parity} |
| lsr | output | 8 | Line status byte |

## Verification
The assertions check several relations on every cycle:
- the data-ready flag never rises without a finished word;
- a word that finishes into a full queue always raises the overrun flag and leaves the head word and the fill level alone;
- a status read empties the sticky flags;
- the error summary is never set while the queue is empty.

Other behaviour depends on frame timing and bit values on the line, so only the bench scenarios can show it. This covers mid-bit start validation, word alignment across all lengths, every parity mode including stick parity, break recognition and the wait for the line to go high, and the order of data after an overrun.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_HOLD
  } rx_state_e;

  // One received word with its error tags.
  typedef struct packed {
    logic       brk;
    logic       frm;
    logic       par;
    logic [7:0] data;
  } rx_word_t;

  // Positions in the line-control byte.
  localparam int LC_PEN   = 3;
  localparam int LC_EVEN  = 4;
  localparam int LC_STICK = 5;

  // Position of each flag in the status byte.
  localparam int ST_READY = 0;
  localparam int ST_OVR   = 1;
  localparam int ST_PAR   = 2;
  localparam int ST_FRM   = 3;
  localparam int ST_BRK   = 4;
  localparam int ST_THE   = 5;
  localparam int ST_TEMT  = 6;
  localparam int ST_FERR  = 7;

  // Number of data bits for a length code.
  function automatic logic [3:0] word_bits(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

  // Shift a right-filled register so the word sits at bit 0.
  function automatic logic [7:0] align_word(input logic [7:0] sh, input logic [1:0] code);
    return sh >> (2'd3 - code);
  endfunction

  // Parity bit expected on the line for an aligned word.
  function automatic logic parity_expected(input logic [7:0] d, input logic even,
                                           input logic stick);
    if (stick) return ~even;
    return even ? (^d) : ~(^d);
  endfunction

  function automatic logic word_has_error(input rx_word_t w);
    return w.brk | w.frm | w.par;
  endfunction

endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rx_line,
  input  logic     baud_tick,
  input  logic [7:0] line_ctrl,
  output logic     word_done,
  output rx_word_t word_out,
  output logic     bit_sample
);
  localparam int CW  = $clog2(OVERSAMPLE);
  localparam int MID = OVERSAMPLE / 2;

  logic [SYNC_STAGES-1:0] sync_q;
  logic        rx_s;
  rx_state_e   st;
  logic [CW-1:0] tcnt;
  logic [2:0]  bitn;
  logic [7:0]  shreg;
  logic [7:0]  lc_q;
  logic        par_bit;
  logic        all_low;
  logic [7:0]  aligned;
  logic        last_data;

  assign rx_s       = sync_q[SYNC_STAGES-1];
  assign aligned    = align_word(shreg, lc_q[1:0]);
  assign last_data  = ({1'b0, bitn} == word_bits(lc_q[1:0]) - 4'd1);
  assign bit_sample = (st != RX_IDLE) && (st != RX_HOLD) && baud_tick &&
                      (tcnt == CW'(OVERSAMPLE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_line};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= RX_IDLE;
      tcnt      <= '0;
      bitn      <= '0;
      shreg     <= '0;
      lc_q      <= '0;
      par_bit   <= 1'b0;
      all_low   <= 1'b0;
      word_done <= 1'b0;
      word_out  <= '0;
    end else begin
      word_done <= 1'b0;
      case (st)
        RX_IDLE: begin
          if (baud_tick && !rx_s) begin
            st   <= RX_START;
            tcnt <= CW'(MID);
            lc_q <= line_ctrl;
          end
        end
        RX_HOLD: begin
          if (rx_s) st <= RX_IDLE;
        end
        default: begin
          if (baud_tick) begin
            if (!bit_sample) begin
              tcnt <= tcnt + 1'b1;
            end else begin
              tcnt <= '0;
              case (st)
                RX_START: begin
                  if (rx_s) begin
                    st <= RX_IDLE;
                  end else begin
                    st      <= RX_DATA;
                    bitn    <= '0;
                    all_low <= 1'b1;
                  end
                end
                RX_DATA: begin
                  shreg   <= {rx_s, shreg[7:1]};
                  all_low <= all_low & ~rx_s;
                  if (last_data) st <= lc_q[LC_PEN] ? RX_PAR : RX_STOP;
                  else           bitn <= bitn + 1'b1;
                end
                RX_PAR: begin
                  par_bit <= rx_s;
                  all_low <= all_low & ~rx_s;
                  st      <= RX_STOP;
                end
                RX_STOP: begin
                  word_done     <= 1'b1;
                  word_out.data <= aligned;
                  word_out.par  <= lc_q[LC_PEN] &
                                   (par_bit != parity_expected(aligned, lc_q[LC_EVEN],
                                                               lc_q[LC_STICK]));
                  word_out.frm  <= ~rx_s;
                  word_out.brk  <= all_low & ~rx_s;
                  st            <= rx_s ? RX_IDLE : RX_HOLD;
                end
                default: st <= RX_IDLE;
              endcase
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  rx_word_t push_word,
  input  logic     pop,
  output rx_word_t head,
  output logic     empty,
  output logic     full,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic     err_present
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  rx_word_t mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] err_cnt;
  logic do_push, do_pop, push_err, pop_err;

  assign empty    = (level == '0);
  assign full     = (level == LW'(DEPTH));
  assign head     = mem[rd_ptr];
  assign do_push  = push & ~full;
  assign do_pop   = pop & ~empty;
  assign push_err = do_push & word_has_error(push_word);
  assign pop_err  = do_pop & word_has_error(head);
  assign err_present = (err_cnt != '0);

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              mem[g] <= '0;
      else if (do_push && wr_ptr == AW'(g))    mem[g] <= push_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level   <= '0;
      err_cnt <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      level   <= level + LW'(do_push) - LW'(do_pop);
      err_cnt <= err_cnt + LW'(push_err) - LW'(pop_err);
    end
  end

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     word_accept,
  input  logic     word_drop,
  input  rx_word_t word_in,
  input  logic     lsr_rd,
  input  logic     fifo_empty,
  input  logic     err_present,
  input  logic     tx_empty,
  input  logic     tx_hold_empty,
  output logic [7:0] lsr
);
  logic ovr_q, par_q, frm_q, brk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      par_q <= 1'b0;
      frm_q <= 1'b0;
      brk_q <= 1'b0;
    end else begin
      ovr_q <= word_drop | (ovr_q & ~lsr_rd);
      par_q <= (word_accept & word_in.par) | (par_q & ~lsr_rd);
      frm_q <= (word_accept & word_in.frm) | (frm_q & ~lsr_rd);
      brk_q <= (word_accept & word_in.brk) | (brk_q & ~lsr_rd);
    end
  end

  always_comb begin
    lsr           = '0;
    lsr[ST_READY] = ~fifo_empty;
    lsr[ST_OVR]   = ovr_q;
    lsr[ST_PAR]   = par_q;
    lsr[ST_FRM]   = frm_q;
    lsr[ST_BRK]   = brk_q;
    lsr[ST_THE]   = tx_hold_empty;
    lsr[ST_TEMT]  = tx_empty;
    lsr[ST_FERR]  = err_present;
  end

endmodule

// File: rtl/uart_rx_lsr.sv
module uart_rx_lsr
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FIFO_DEPTH  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_line,
  input  logic       baud_tick,
  input  logic [7:0] line_ctrl,
  input  logic       rd_data_stb,
  input  logic       lsr_rd_stb,
  input  logic       tx_empty,
  input  logic       tx_hold_empty,
  output logic [7:0] rd_data,
  output logic [2:0] rd_err,
  output logic [7:0] lsr
);
  localparam int LW = $clog2(FIFO_DEPTH + 1);

  logic     word_done;
  rx_word_t word_new;
  logic     bit_sample;
  logic     fifo_empty, fifo_full, err_present;
  logic [LW-1:0] fifo_level;
  rx_word_t head;
  logic     word_accept, word_drop;

  assign word_accept = word_done & ~fifo_full;
  assign word_drop   = word_done & fifo_full;
  assign rd_data     = head.data;
  assign rd_err      = {head.brk, head.frm, head.par};

  uart_rx_frame #(
    .OVERSAMPLE (OVERSAMPLE),
    .SYNC_STAGES(SYNC_STAGES)
  ) frame_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_line   (rx_line),
    .baud_tick (baud_tick),
    .line_ctrl (line_ctrl),
    .word_done (word_done),
    .word_out  (word_new),
    .bit_sample(bit_sample)
  );

  uart_rx_fifo #(.DEPTH(FIFO_DEPTH)) fifo_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (word_accept),
    .push_word  (word_new),
    .pop        (rd_data_stb),
    .head       (head),
    .empty      (fifo_empty),
    .full       (fifo_full),
    .level      (fifo_level),
    .err_present(err_present)
  );

  uart_rx_status status_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_accept  (word_accept),
    .word_drop    (word_drop),
    .word_in      (word_new),
    .lsr_rd       (lsr_rd_stb),
    .fifo_empty   (fifo_empty),
    .err_present  (err_present),
    .tx_empty     (tx_empty),
    .tx_hold_empty(tx_hold_empty),
    .lsr          (lsr)
  );

endmodule

// File: rtl/uart_rx_lsr_chk.sv
module uart_rx_lsr_chk #(
  parameter int DEPTH = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       word_done,
  input logic       fifo_full,
  input logic [$clog2(DEPTH+1)-1:0] fifo_level,
  input logic [7:0] lsr,
  input logic       lsr_rd_stb,
  input logic       rd_data_stb,
  input logic [7:0] rd_data
);
  localparam int LW = $clog2(DEPTH + 1);

  assert_ready_after_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lsr[0]) |-> $past(word_done));

  assert_overrun_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && fifo_full) |=> lsr[1]);

  assert_keep_old_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && fifo_full && !rd_data_stb) |=> ($stable(rd_data) && fifo_level == LW'(DEPTH)));

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd_stb && !word_done) |=> (lsr[4:1] == 4'b0000));

  assert_summary_needs_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !lsr[0] |-> !lsr[7]);

  assert_level_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LW'(DEPTH));

endmodule

bind uart_rx_lsr uart_rx_lsr_chk #(.DEPTH(FIFO_DEPTH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .word_done  (word_done),
  .fifo_full  (fifo_full),
  .fifo_level (fifo_level),
  .lsr        (lsr),
  .lsr_rd_stb (lsr_rd_stb),
  .rd_data_stb(rd_data_stb),
  .rd_data    (rd_data)
);

// File: tb/uart_rx_lsr_tb_top.sv
`timescale 1ns/1ps
module uart_rx_lsr_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       baud_tick = 1'b0;
  logic [7:0] line_ctrl = 8'h03;
  logic       rd_data_stb = 1'b0;
  logic       lsr_rd_stb = 1'b0;
  logic       tx_empty = 1'b1;
  logic       tx_hold_empty = 1'b1;
  logic [7:0] rd_data;
  logic [2:0] rd_err;
  logic [7:0] lsr;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  uart_rx_lsr dut_i (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .baud_tick(baud_tick),
    .line_ctrl(line_ctrl), .rd_data_stb(rd_data_stb), .lsr_rd_stb(lsr_rd_stb),
    .tx_empty(tx_empty), .tx_hold_empty(tx_hold_empty),
    .rd_data(rd_data), .rd_err(rd_err), .lsr(lsr)
  );

  always #2.5 clk = ~clk;
  always @(negedge clk) baud_tick <= ~baud_tick;   // strobe every other clock

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000 && !done) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic exp_par(input logic [7:0] d, input logic [7:0] lc);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += d[i];
    if (lc[5]) return lc[4] ? 1'b0 : 1'b1;
    if (lc[4]) return (ones % 2) == 1;     // make total even
    return (ones % 2) == 0;                // make total odd
  endfunction

  function automatic logic [7:0] len_mask(input logic [7:0] lc);
    return 8'hFF >> (3 - lc[1:0]);
  endfunction

  task automatic bit_time(input logic v);
    rx_line = v;
    repeat (32) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic [7:0] lc,
                            input logic flip_par, input logic stop_v);
    logic [7:0] dm;
    dm = d & len_mask(lc);
    @(negedge clk);
    line_ctrl = lc;
    bit_time(1'b0);
    for (int i = 0; i < 5 + lc[1:0]; i++) bit_time(dm[i]);
    if (lc[3]) bit_time(exp_par(dm, lc) ^ flip_par);
    bit_time(stop_v);
    bit_time(1'b1);
  endtask

  task automatic pop();
    @(negedge clk) rd_data_stb = 1'b1;
    @(negedge clk) rd_data_stb = 1'b0;
  endtask

  task automatic read_lsr();
    @(negedge clk) lsr_rd_stb = 1'b1;
    @(negedge clk) lsr_rd_stb = 1'b0;
  endtask

  initial begin
    logic [7:0] d, lc;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6 reset status", {8'h0, lsr}, 16'h0060);
    tx_empty = 1'b0;
    @(negedge clk);
    chk("R10 tx empty passthrough", {15'h0, lsr[6]}, 16'h0);
    tx_hold_empty = 1'b0;
    @(negedge clk);
    chk("R10 hold empty passthrough", {15'h0, lsr[5]}, 16'h0);
    tx_empty = 1'b1; tx_hold_empty = 1'b1;

    // R2 R3 R11: random formats and data
    for (int n = 0; n < 24; n++) begin
      d  = 8'($urandom);
      lc = {2'b00, 1'($urandom), 1'($urandom), 1'($urandom), 1'b0, 2'($urandom)};
      send_frame(d, lc, 1'b0, 1'b1);
      chk("R2 data", {8'h0, rd_data}, {8'h0, d & len_mask(lc)});
      chk("R3 no error tag", {13'h0, rd_err}, 16'h0);
      chk("R6 ready", {15'h0, lsr[0]}, 16'h1);
      pop();
      chk("R11 pop empties", {15'h0, lsr[0]}, 16'h0);
    end

    // R1: short low glitch
    @(negedge clk) rx_line = 1'b0;
    repeat (6) @(negedge clk);
    rx_line = 1'b1;
    repeat (96) @(negedge clk);
    chk("R1 glitch ignored", {8'h0, lsr}, 16'h0060);

    // R3: stick parity, expect 0 with even select
    send_frame(8'h5A, 8'h3B, 1'b0, 1'b1);
    chk("R3 stick good", {13'h0, rd_err}, 16'h0);
    pop();
    send_frame(8'h5A, 8'h3B, 1'b1, 1'b1);
    chk("R3 stick bad tag", {13'h0, rd_err}, 16'h1);
    chk("R3 stick bad status", {15'h0, lsr[2]}, 16'h1);
    chk("R9 summary set", {15'h0, lsr[7]}, 16'h1);
    pop();
    chk("R9 summary cleared", {15'h0, lsr[7]}, 16'h0);
    read_lsr();
    chk("R8 flags cleared", {12'h0, lsr[4:1]}, 16'h0);

    // R9: bad word then good word
    send_frame(8'h31, 8'h1B, 1'b1, 1'b1);
    send_frame(8'h32, 8'h1B, 1'b0, 1'b1);
    chk("R9 summary with two words", {15'h0, lsr[7]}, 16'h1);
    pop();
    chk("R9 summary after bad word popped", {15'h0, lsr[7]}, 16'h0);
    chk("R11 second word at head", {8'h0, rd_data}, 16'h0032);
    pop();
    read_lsr();

    // R4: framing error
    send_frame(8'hC3, 8'h03, 1'b0, 1'b0);
    chk("R4 framing tag", {13'h0, rd_err}, 16'h2);
    chk("R4 framing status", {15'h0, lsr[3]}, 16'h1);
    chk("R4 data kept", {8'h0, rd_data}, 16'h00C3);
    pop();
    read_lsr();

    // R5 R12: long break, one word only
    @(negedge clk) line_ctrl = 8'h03;
    bit_time(1'b0);
    for (int i = 0; i < 14; i++) bit_time(1'b0);
    bit_time(1'b1); bit_time(1'b1);
    chk("R5 break data", {8'h0, rd_data}, 16'h0);
    chk("R5 break tags", {13'h0, rd_err}, 16'h6);
    chk("R5 break status", {15'h0, lsr[4]}, 16'h1);
    pop();
    chk("R12 single word for break", {15'h0, lsr[0]}, 16'h0);
    read_lsr();

    // R7: overrun keeps old words
    for (int i = 0; i < 5; i++) send_frame(8'hA0 + 8'(i), 8'h03, 1'b0, 1'b1);
    chk("R7 overrun status", {15'h0, lsr[1]}, 16'h1);
    for (int i = 0; i < 4; i++) begin
      chk("R7 old word order", {8'h0, rd_data}, {8'h0, 8'hA0 + 8'(i)});
      pop();
    end
    chk("R7 new word dropped", {15'h0, lsr[0]}, 16'h0);
    read_lsr();
    chk("R8 overrun cleared", {15'h0, lsr[1]}, 16'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule